// File: doc/BRIEF.md
# Ethernet Address Hash Filter

This block sits beside a receive MAC and decides, while a frame's destination address streams past, whether the frame is wanted. The six address bytes arrive one per valid cycle after a frame-start pulse. Each byte is folded into a reflected CRC-32, least significant bit first. When all six bytes have been seen, the top six bits of the CRC select one bit of a 64-bit hash table. That table is supplied as two 32-bit words. At the same time the address is compared exactly against a programmed station address.

A small state machine has three states. Idle waits for the first frame start. Collect counts address bytes. Decided holds the verdict. There are three transitions. Any state goes to Collect on a frame-start pulse. Collect goes to Decided on the sixth accepted byte. Decided stays put until the next frame start. The frame is accepted when the exact compare matches, when the selected table bit is one, or when promiscuous mode is asserted. The verdict and its components are registered on the sixth byte and held through the rest of the frame.

Top module: `addr_hash_filter`

## Requirements
- R1: On every `frame_start` pulse the CRC restarts from all ones and the byte count restarts from zero, so a frame start in the middle of an address discards the bytes already seen.
- R2: Each byte is consumed bit 0 first. When the incoming bit differs from CRC bit 0, the CRC is shifted right and XORed with 0xEDB88320; otherwise it is only shifted right. After six bytes, `hash_index` equals CRC bits 31 to 26.
- R3: `hash_hit` is bit (`hash_index` - 32) of `hash_hi` when `hash_index` is 32 or more, and bit `hash_index` of `hash_lo` otherwise.
- R4: `exact_hit` is 1 when the six address bytes, in arrival order, equal `station_a[31:24]`, `station_a[23:16]`, `station_a[15:8]`, `station_a[7:0]`, `station_b[31:24]` and `station_b[23:16]`. `station_b[15:0]` has no effect.
- R5: `accept` equals `exact_hit` OR `hash_hit` OR the value of `promisc` in the cycle of the sixth byte.
- R6: `decision_valid`, `accept`, `exact_hit`, `hash_hit` and `hash_index` update on the clock edge that takes the sixth byte, so they are visible the next cycle. They then hold, and further bytes before the next `frame_start` are ignored.
- R7: A `frame_start` clears `decision_valid` and `accept` from the next cycle. A byte presented in the same cycle as `frame_start`, or before any frame start after reset, is ignored.
- R8: After reset, `decision_valid`, `accept`, `exact_hit`, `hash_hit` and `hash_index` are 0.
- R9: Cycles with `byte_valid` low inside the address field neither advance the count nor change the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| byte_valid | input | 1 | `byte_data` carries an address byte |
| byte_data | input | 8 | Address byte, first byte first |
| promisc | input | 1 | Accept every frame |
| hash_lo | input | 32 | Table bits for indexes 0 to 31 |
| hash_hi | input | 32 | Table bits for indexes 32 to 63 |
| station_a | input | 32 | Station address bytes 0 to 3, byte 0 in the top byte |
| station_b | input | 32 | Station address bytes 4 and 5 in the top half |
| decision_valid | output | 1 | Verdict for the current frame is available |
| accept | output | 1 | Frame accepted |
| exact_hit | output | 1 | Station address matched |
| hash_hit | output | 1 | Selected hash table bit was one |
| hash_index | output | 6 | Six-bit hash of the address |

## Verification
The bench goes after the bit order and the table split. It drives addresses whose hash lands in each half of the table, with only that half populated. A design that shifted bits in most significant first, or that swapped the two table words, would report hash indexes or hits that disagree with the model. It restarts a frame part way through an address, and sends extra bytes after the verdict and bytes before any frame start. A design that kept stale CRC state, or let trailing bytes change the result, would show a wrong index or a verdict that moved. It also programs random values into the unused low half of the station word, so a design that compared that half would miss exact matches.

// File: rtl/ahf_pkg.sv
package ahf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDED = 2'd2
    } ahf_state_t;
endpackage

// File: rtl/ahf_crc_engine.sv
module ahf_crc_engine #(
    parameter int CRC_W = 32,
    parameter int DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              step,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_q,
    output logic [CRC_W-1:0]  crc_next
);
    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = crc_q;

    // one reflected shift per data bit, bit 0 first
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign stage[b+1] = (data[b] ^ stage[b][0]) ? ((stage[b] >> 1) ^ POLY)
                                                         : (stage[b] >> 1);
        end
    endgenerate

    assign crc_next = init ? '1 : (step ? stage[DATA_W] : crc_q);

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_next;
    end
endmodule

// File: rtl/ahf_addr_capture.sv
module ahf_addr_capture #(
    parameter int BYTES = 6,
    parameter int CNT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [CNT_W-1:0]   slot,
    input  logic [7:0]         data,
    output logic [BYTES*8-1:0] addr_next
);
    // first byte lands in the most significant position
    generate
        for (genvar k = 0; k < BYTES; k++) begin : g_slot
            logic [7:0] held;
            logic       sel;
            assign sel = step && (slot == CNT_W'(k));
            always_ff @(posedge clk) begin
                if (!rst_n)   held <= '0;
                else if (sel) held <= data;
            end
            assign addr_next[(BYTES-1-k)*8 +: 8] = sel ? data : held;
        end
    endgenerate
endmodule

// File: rtl/ahf_match.sv
module ahf_match #(
    parameter int ADDR_W = 48,
    parameter int CRC_W = 32,
    parameter int IDX_W = 6,
    localparam int TBL_W = 1 << IDX_W,
    localparam int HALF_W = TBL_W / 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] station,
    input  logic [CRC_W-1:0]  crc,
    input  logic [HALF_W-1:0] hash_lo,
    input  logic [HALF_W-1:0] hash_hi,
    output logic              exact,
    output logic              hash_bit,
    output logic [IDX_W-1:0]  index
);
    logic [TBL_W-1:0] table_v;

    assign index    = crc[CRC_W-1 -: IDX_W];
    assign table_v  = {hash_hi, hash_lo};
    assign hash_bit = table_v[index];
    assign exact    = (addr == station);
endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int CRC_W = 32,
    parameter int IDX_W = 6,
    localparam int ADDR_W = ADDR_BYTES * 8,
    localparam int CNT_W = $clog2(ADDR_BYTES),
    localparam int HALF_W = (1 << IDX_W) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              promisc,
    input  logic [HALF_W-1:0] hash_lo,
    input  logic [HALF_W-1:0] hash_hi,
    input  logic [31:0]       station_a,
    input  logic [31:0]       station_b,
    output logic              decision_valid,
    output logic              accept,
    output logic              exact_hit,
    output logic              hash_hit,
    output logic [IDX_W-1:0]  hash_index
);
    import ahf_pkg::*;

    ahf_state_t       state_q, state_d;
    logic [CNT_W-1:0] byte_cnt;
    logic             step, seal;
    logic [CRC_W-1:0] crc_q, crc_next;
    logic [ADDR_W-1:0] addr_next, station;
    logic             exact_w, hash_w;
    logic [IDX_W-1:0] index_w;

    assign station = {station_a, station_b[31:16]};
    assign step    = (state_q == ST_COLLECT) && byte_valid && !frame_start;
    assign seal    = step && (byte_cnt == CNT_W'(ADDR_BYTES - 1));

    ahf_crc_engine #(.CRC_W(CRC_W), .DATA_W(8)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(frame_start), .step(step),
        .data(byte_data), .crc_q(crc_q), .crc_next(crc_next)
    );

    ahf_addr_capture #(.BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .step(step), .slot(byte_cnt),
        .data(byte_data), .addr_next(addr_next)
    );

    ahf_match #(.ADDR_W(ADDR_W), .CRC_W(CRC_W), .IDX_W(IDX_W)) u_match (
        .addr(addr_next), .station(station), .crc(crc_next),
        .hash_lo(hash_lo), .hash_hi(hash_hi),
        .exact(exact_w), .hash_bit(hash_w), .index(index_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (frame_start) state_d = ST_COLLECT;
            ST_COLLECT: if (frame_start) state_d = ST_COLLECT;
                        else if (seal)   state_d = ST_DECIDED;
            ST_DECIDED: if (frame_start) state_d = ST_COLLECT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            byte_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (frame_start)  byte_cnt <= '0;
            else if (step)    byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // registered verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decision_valid <= 1'b0;
            accept         <= 1'b0;
            exact_hit      <= 1'b0;
            hash_hit       <= 1'b0;
            hash_index     <= '0;
        end else if (frame_start) begin
            decision_valid <= 1'b0;
            accept         <= 1'b0;
            exact_hit      <= 1'b0;
            hash_hit       <= 1'b0;
            hash_index     <= '0;
        end else if (seal) begin
            decision_valid <= 1'b1;
            accept         <= promisc | exact_w | hash_w;
            exact_hit      <= exact_w;
            hash_hit       <= hash_w;
            hash_index     <= index_w;
        end
    end
endmodule

// File: rtl/ahf_checker.sv
module ahf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       promisc,
    input logic       decision_valid,
    input logic       accept,
    input logic       exact_hit,
    input logic       hash_hit,
    input logic [5:0] hash_index
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!decision_valid && !accept)); // R7

    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && !frame_start) |=> (decision_valid && $stable(accept) && $stable(hash_index))); // R6

    AST_PROMISC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(decision_valid) && $past(promisc)) |-> accept); // R5

    AST_REJECT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && !accept) |-> (!exact_hit && !hash_hit)); // R5

    AST_HIT_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (exact_hit || hash_hit) |-> (accept && decision_valid)); // R5
endmodule

bind addr_hash_filter ahf_checker u_ahf_checker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .promisc(promisc),
    .decision_valid(decision_valid), .accept(accept), .exact_hit(exact_hit),
    .hash_hit(hash_hit), .hash_index(hash_index)
);

// File: tb/addr_hash_filter_tb_top.sv
`timescale 1ns/1ps
module addr_hash_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, byte_valid = 1'b0, promisc = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [31:0] hash_lo = '0, hash_hi = '0, station_a = '0, station_b = '0;
    logic        decision_valid, accept, exact_hit, hash_hit;
    logic [5:0]  hash_index;
    int          n_chk = 0, n_bad = 0;
    int          cyc = 0;

    always #4 clk = ~clk;

    addr_hash_filter dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .promisc(promisc), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .station_a(station_a), .station_b(station_b), .decision_valid(decision_valid),
        .accept(accept), .exact_hit(exact_hit), .hash_hit(hash_hit), .hash_index(hash_index)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  b;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            b = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                if (b[j] ^ c[0]) c = (c >> 1) ^ 32'hEDB88320;
                else             c = c >> 1;
            end
        end
        return c;
    endfunction

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        c = ref_crc(a);
        return c[31:26];
    endfunction

    function automatic logic ref_hash(input logic [47:0] a);
        logic [5:0] ix;
        ix = ref_idx(a);
        if (ix >= 6'd32) return hash_hi[ix - 6'd32];
        return hash_lo[ix[4:0]];
    endfunction

    function automatic logic ref_exact(input logic [47:0] a);
        return a == {station_a, station_b[31:16]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic send_addr(input logic [47:0] a, input bit gaps);
        for (int i = 0; i < 6; i++) begin
            if (gaps && i[0]) begin
                byte_data = 8'hA5;
                @(negedge clk);
            end
            send_byte(a[47-8*i -: 8]);
        end
    endtask

    task automatic frame(input logic [47:0] a, input bit gaps);
        pulse_start();
        send_addr(a, gaps);
    endtask

    task automatic check_all(input string tag, input logic [47:0] a);
        logic h, e;
        h = ref_hash(a);
        e = ref_exact(a);
        chk({tag, " R6 valid"}, decision_valid, 1);
        chk({tag, " R2 index"}, hash_index, ref_idx(a));
        chk({tag, " R3 hash"}, hash_hit, h);
        chk({tag, " R4 exact"}, exact_hit, e);
        chk({tag, " R5 accept"}, accept, h | e | promisc);
    endtask

    function automatic logic [47:0] rand_addr();
        return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    endfunction

    initial begin
        logic [47:0] a;
        logic [5:0]  ix;
        logic        sa;
        logic [5:0]  si;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R8 valid", decision_valid, 0);
        chk("R8 accept", accept, 0);
        chk("R8 index", hash_index, 0);
        chk("R8 hits", {exact_hit, hash_hit}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: bytes before any frame start are ignored
        for (int i = 0; i < 8; i++) send_byte(8'h11 * i[7:0]);
        chk("R7 idle bytes", decision_valid, 0);

        // R3: index in upper half, only upper table populated
        do a = rand_addr(); while (ref_idx(a) < 6'd32);
        ix = ref_idx(a);
        hash_hi = 32'h1 << (ix - 6'd32); hash_lo = '0;
        station_a = ~a[47:16]; station_b = '0;
        frame(a, 0);
        check_all("hi", a);
        chk("R3 hi hit", hash_hit, 1);

        // R3: same index bit placed in lower register must not hit
        hash_lo = hash_hi; hash_hi = '0;
        frame(a, 0);
        chk("R3 hi miss", hash_hit, 0);
        chk("R5 reject", accept, 0);

        // R3: index in lower half
        do a = rand_addr(); while (ref_idx(a) >= 6'd32);
        ix = ref_idx(a);
        hash_lo = 32'h1 << ix; hash_hi = '0;
        frame(a, 1);
        check_all("lo R9", a);
        chk("R3 lo hit", hash_hit, 1);

        // R6: trailing bytes ignored, verdict held
        sa = accept; si = hash_index;
        for (int i = 0; i < 4; i++) send_byte(8'hFF - i[7:0]);
        chk("R6 held accept", accept, sa);
        chk("R6 held index", hash_index, si);
        chk("R6 held valid", decision_valid, 1);

        // R7: frame start clears verdict
        pulse_start();
        chk("R7 cleared", decision_valid, 0);
        chk("R7 cleared acc", accept, 0);

        // R4: exact match, low half of station_b random
        hash_lo = '0; hash_hi = '0;
        a = rand_addr();
        station_a = a[47:16]; station_b = {a[15:0], 16'h3C5A};
        frame(a, 0);
        check_all("exact", a);
        chk("R4 exact hit", exact_hit, 1);
        // R4: one bit off in last byte
        frame(a ^ 48'h1, 0);
        chk("R4 exact miss", exact_hit, 0);

        // R5: promiscuous mode
        promisc = 1'b1;
        frame(a ^ 48'h100, 0);
        chk("R5 promisc", accept, 1);
        promisc = 1'b0;

        // R1: restart mid-address, plus byte in frame-start cycle ignored (R7)
        a = rand_addr();
        pulse_start();
        send_byte(8'h5A); send_byte(8'hC3); send_byte(8'h0F);
        @(negedge clk);
        frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'h77;
        @(negedge clk);
        frame_start = 1'b0; byte_valid = 1'b0;
        send_addr(a, 0);
        check_all("R1 restart", a);

        // random mix
        for (int n = 0; n < 60; n++) begin
            hash_lo = $urandom; hash_hi = $urandom;
            promisc = ($urandom % 8) == 0;
            a = rand_addr();
            if ($urandom % 4 == 0) begin
                station_a = a[47:16]; station_b = {a[15:0], 16'($urandom)};
            end else begin
                station_a = $urandom; station_b = $urandom;
            end
            frame(a, $urandom % 2 == 1);
            check_all("rand", a);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule